// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request (bus number, device slot, function number and register offset) into the two values that software or a sequencer writes into an outbound translation window before it touches configuration space. The first value is the PCI address presented in the window. The second is the map-register word that sets the cycle type and the handling of the two lowest address bits.

Requests on the local segment (bus 0) become type 0 cycles. The target device is chosen by a single select line. For slots 0 to 12 that line is an address bit. For slots 13 to 31 it moves into the upper part of the map word, because the address does not have enough room for it. Requests for any other bus become type 1 cycles, which carry bus, slot and function as packed fields.

A request is a one-cycle strobe with the fields beside it. One cycle later the block presents a registered result with a one-cycle valid pulse. A request with a slot or function outside the legal range produces a one-cycle error pulse instead.

Top module: `cfg_addr_gen`

## Requirements
- R1: The cycle type follows the bus number. When bus_i is 0, map_o bit 0 is 0, so PCI address bits 1:0 are forced to zero. For any other bus, map_o bit 0 is 1, so those bits come from the host address.
- R2: Every valid result has the configuration cycle code 3'b101 in map_o bits 3:1.
- R3: For a type 0 result, addr_o bits 10:8 hold the function number and addr_o bits 7:0 hold the register offset.
- R4: For a type 0 result with slot 0..12, addr_o bit (slot+11) is the only bit set in addr_o[31:11], and map_o bits 31:4 are all zero.
- R5: For a type 0 result with slot 13..31, map_o bit (slot-5) is the only bit set in map_o[31:4], and addr_o bits 31:11 are all zero.
- R6: For a type 1 result, addr_o is {8'h00, bus[7:0], slot[4:0], func[2:0], offset[7:0]} from bit 31 down to bit 0, and map_o bits 31:4 are zero.
- R7: A request with slot above 31 or function above 7 gives no valid. It raises err_o for exactly one cycle and leaves addr_o and map_o unchanged.
- R8: valid_o or err_o rises in the cycle after the request strobe and lasts one cycle per strobe cycle. Back-to-back strobes give back-to-back results. Without a strobe, both stay low.
- R9: While reset is held, valid_o and err_o are low and addr_o and map_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one cycle per request |
| bus_i | input | 8 | Target bus number |
| slot_i | input | 6 | Target device slot; values above 31 are illegal |
| func_i | input | 4 | Target function; values above 7 are illegal |
| offs_i | input | 8 | Configuration register byte offset |
| addr_o | output | 32 | Registered PCI configuration address |
| map_o | output | 32 | Registered map-register word |
| valid_o | output | 1 | One-cycle pulse: addr_o and map_o hold a new result |
| err_o | output | 1 | One-cycle pulse: the request was rejected |

## Verification
The properties compare each output pulse with the strobe and bus number of the cycle before. They rely on req_i being low whenever reset is applied, and on bus_i being held stable together with the strobe. The stimulus meets this by driving every input only on the falling clock edge and holding the strobe low through reset.

The random slot range runs past 31 and the function range past 7, so rejected requests are mixed in with legal ones. Directed cases cover the type 0 boundary between slots 12 and 13, slot 31, function 7, bus 255, and strobes on consecutive cycles.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int BUS_W     = 8;
  localparam int SLOT_W    = 5;
  localparam int SLOT_IN_W = SLOT_W + 1;
  localparam int FUNC_W    = 3;
  localparam int FUNC_IN_W = FUNC_W + 1;
  localparam int OFF_W     = 8;
  localparam int ADDR_W    = 32;
  localparam int MAP_W     = 32;
  localparam int SLOT_MAX  = (1 << SLOT_W) - 1;
  localparam int FUNC_MAX  = (1 << FUNC_W) - 1;

  // configuration cycle code placed in map bits 3:1
  localparam logic [2:0] CFG_CODE = 3'b101;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [MAP_W-1:0]  map;
  } cfg_word_t;

  // type 0 address: select line for low slots, function and offset
  function automatic logic [ADDR_W-1:0] t0_addr(input logic [SLOT_W-1:0] slot,
                                                input logic [FUNC_W-1:0] fn,
                                                input logic [OFF_W-1:0]  off,
                                                input int low_max,
                                                input int sel_base);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'({fn, off});
    if (int'(slot) <= low_max)
      a = a | (ADDR_W'(1) << (int'(slot) + sel_base));
    return a;
  endfunction

  // type 0 map word: code, low bits forced to zero, select for high slots
  function automatic logic [MAP_W-1:0] t0_map(input logic [SLOT_W-1:0] slot,
                                              input int low_max,
                                              input int map_shift);
    logic [MAP_W-1:0] m;
    m = MAP_W'({CFG_CODE, 1'b0});
    if (int'(slot) > low_max)
      m = m | (MAP_W'(1) << (int'(slot) - map_shift));
    return m;
  endfunction

  // type 1 address: packed bus, slot, function and offset fields
  function automatic logic [ADDR_W-1:0] t1_addr(input logic [BUS_W-1:0]  bus,
                                                input logic [SLOT_W-1:0] slot,
                                                input logic [FUNC_W-1:0] fn,
                                                input logic [OFF_W-1:0]  off);
    return ADDR_W'({bus, slot, fn, off});
  endfunction

  // type 1 map word: code, low address bits passed from the host
  function automatic logic [MAP_W-1:0] t1_map();
    return MAP_W'({CFG_CODE, 1'b1});
  endfunction
endpackage

// File: rtl/cfg_req_decode.sv
module cfg_req_decode
  import cfg_pkg::*;
#(
  parameter int SLOT_LIMIT = SLOT_MAX,
  parameter int FUNC_LIMIT = FUNC_MAX
) (
  input  logic [BUS_W-1:0]     bus_i,
  input  logic [SLOT_IN_W-1:0] slot_i,
  input  logic [FUNC_IN_W-1:0] func_i,
  output logic                 fields_ok_o,
  output logic                 local_seg_o
);
  logic slot_ok_w;
  logic func_ok_w;

  assign slot_ok_w   = slot_i <= SLOT_IN_W'(SLOT_LIMIT);
  assign func_ok_w   = func_i <= FUNC_IN_W'(FUNC_LIMIT);
  assign fields_ok_o = slot_ok_w && func_ok_w;
  assign local_seg_o = (bus_i == '0);
endmodule

// File: rtl/cfg_t0_enc.sv
module cfg_t0_enc
  import cfg_pkg::*;
#(
  parameter int LOW_SLOT_MAX = 12,
  parameter int SEL_BASE     = 11,
  parameter int MAP_SHIFT    = 5
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [OFF_W-1:0]  offs_i,
  output cfg_word_t         word_o
);
  localparam int TOP_ADDR_SEL = LOW_SLOT_MAX + SEL_BASE;
  localparam int TOP_MAP_SEL  = SLOT_MAX - MAP_SHIFT;

  generate
    if (TOP_ADDR_SEL >= ADDR_W || TOP_MAP_SEL >= MAP_W || TOP_MAP_SEL < 4) begin : g_bad_cfg
      initial $error("cfg_t0_enc: select position out of range");
    end
  endgenerate

  always_comb begin
    word_o.addr = t0_addr(slot_i, func_i, offs_i, LOW_SLOT_MAX, SEL_BASE);
    word_o.map  = t0_map(slot_i, LOW_SLOT_MAX, MAP_SHIFT);
  end
endmodule

// File: rtl/cfg_t1_enc.sv
module cfg_t1_enc
  import cfg_pkg::*;
(
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [OFF_W-1:0]  offs_i,
  output cfg_word_t         word_o
);
  always_comb begin
    word_o.addr = t1_addr(bus_i, slot_i, func_i, offs_i);
    word_o.map  = t1_map();
  end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_pkg::*;
#(
  parameter int LOW_SLOT_MAX = 12,
  parameter int SEL_BASE     = 11,
  parameter int MAP_SHIFT    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic [BUS_W-1:0]     bus_i,
  input  logic [SLOT_IN_W-1:0] slot_i,
  input  logic [FUNC_IN_W-1:0] func_i,
  input  logic [OFF_W-1:0]     offs_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [MAP_W-1:0]     map_o,
  output logic                 valid_o,
  output logic                 err_o
);
  logic      fields_ok_w;
  logic      local_seg_w;
  logic      accept_w;
  logic      reject_w;
  cfg_word_t t0_word_w;
  cfg_word_t t1_word_w;
  cfg_word_t next_word_w;

  cfg_req_decode #(
    .SLOT_LIMIT(SLOT_MAX),
    .FUNC_LIMIT(FUNC_MAX)
  ) u_decode (
    .bus_i      (bus_i),
    .slot_i     (slot_i),
    .func_i     (func_i),
    .fields_ok_o(fields_ok_w),
    .local_seg_o(local_seg_w)
  );

  cfg_t0_enc #(
    .LOW_SLOT_MAX(LOW_SLOT_MAX),
    .SEL_BASE    (SEL_BASE),
    .MAP_SHIFT   (MAP_SHIFT)
  ) u_t0 (
    .slot_i(slot_i[SLOT_W-1:0]),
    .func_i(func_i[FUNC_W-1:0]),
    .offs_i(offs_i),
    .word_o(t0_word_w)
  );

  cfg_t1_enc u_t1 (
    .bus_i (bus_i),
    .slot_i(slot_i[SLOT_W-1:0]),
    .func_i(func_i[FUNC_W-1:0]),
    .offs_i(offs_i),
    .word_o(t1_word_w)
  );

  assign accept_w    = req_i && fields_ok_w;
  assign reject_w    = req_i && !fields_ok_w;
  assign next_word_w = local_seg_w ? t0_word_w : t1_word_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o  <= '0;
      map_o   <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= accept_w;
      err_o   <= reject_w;
      if (accept_w) begin
        addr_o <= next_word_w.addr;
        map_o  <= next_word_w.map;
      end
    end
  end
endmodule

// File: rtl/cfg_addr_gen_chk.sv
module cfg_addr_gen_chk
  import cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [BUS_W-1:0]  bus_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [MAP_W-1:0]  map_o,
  input logic              valid_o,
  input logic              err_o
);
  // R1
  type_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (map_o[0] == ($past(bus_i) != '0)));

  // R2
  map_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (map_o[3:1] == 3'b101));

  // R4
  t0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !map_o[0]) |-> ($countones({addr_o[ADDR_W-1:11], map_o[MAP_W-1:4]}) == 1));

  // R6
  t1_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && map_o[0]) |-> (addr_o[ADDR_W-1:24] == '0 && map_o[MAP_W-1:4] == '0));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(addr_o) && $stable(map_o)));

  // R8
  resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || err_o) |-> $past(req_i));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_i) |-> (!valid_o && !err_o));

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));
endmodule

bind cfg_addr_gen cfg_addr_gen_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .bus_i  (bus_i),
  .addr_o (addr_o),
  .map_o  (map_o),
  .valid_o(valid_o),
  .err_o  (err_o)
);

// File: tb/test_cfg_addr_gen.sv
module test_cfg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  bus_i = '0;
  logic [5:0]  slot_i = '0;
  logic [3:0]  func_i = '0;
  logic [7:0]  offs_i = '0;
  logic [31:0] addr_o, map_o;
  logic        valid_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] last_addr = '0, last_map = '0;

  always #4 clk = ~clk;

  cfg_addr_gen i_cfg_addr_gen (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_i(bus_i), .slot_i(slot_i),
    .func_i(func_i), .offs_i(offs_i), .addr_o(addr_o), .map_o(map_o),
    .valid_o(valid_o), .err_o(err_o)
  );

  function automatic logic [31:0] ref_addr(input logic [7:0] b, input logic [5:0] s,
                                           input logic [3:0] f, input logic [7:0] o);
    logic [31:0] a;
    if (b == 0) begin
      a = {21'd0, f[2:0], o};
      if (s < 13) a = a | (32'h0000_0800 << s);
    end else begin
      a = {8'h00, b, s[4:0], f[2:0], o};
    end
    return a;
  endfunction

  function automatic logic [31:0] ref_map(input logic [7:0] b, input logic [5:0] s);
    logic [31:0] m;
    if (b != 0) m = 32'h0000_000B;
    else begin
      m = 32'h0000_000A;
      if (s >= 13) m = m | (32'h0000_0100 << (s - 13));
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b, input logic [5:0] s, input logic [3:0] f,
                       input logic [7:0] o);
    logic good;
    string tag;
    good = (s <= 31) && (f <= 7);
    @(negedge clk);
    req_i = 1'b1; bus_i = b; slot_i = s; func_i = f; offs_i = o;
    @(negedge clk);
    req_i = 1'b0;
    if (good) begin
      tag = (b != 0) ? "R6" : ((s < 13) ? "R4" : "R5");
      check("R8 valid", {31'd0, valid_o}, 32'd1);
      check("R7 no err", {31'd0, err_o}, 32'd0);
      check({tag, "/R3 addr"}, addr_o, ref_addr(b, s, f, o));
      check({tag, "/R1/R2 map"}, map_o, ref_map(b, s));
      last_addr = ref_addr(b, s, f, o);
      last_map  = ref_map(b, s);
    end else begin
      check("R7 err", {31'd0, err_o}, 32'd1);
      check("R7 no valid", {31'd0, valid_o}, 32'd0);
      check("R7 addr held", addr_o, last_addr);
      check("R7 map held", map_o, last_map);
    end
    @(negedge clk);
    check("R8 valid pulse ends", {31'd0, valid_o}, 32'd0);
    check("R8 err pulse ends", {31'd0, err_o}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    // R9
    check("R9 valid", {31'd0, valid_o}, 32'd0);
    check("R9 err", {31'd0, err_o}, 32'd0);
    check("R9 addr", addr_o, 32'd0);
    check("R9 map", map_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 idle
    check("R8 idle", {30'd0, valid_o, err_o}, 32'd0);

    issue(8'd0, 6'd0, 4'd0, 8'h00);   // R4 lowest
    issue(8'd0, 6'd12, 4'd7, 8'hFC);  // R4 boundary
    issue(8'd0, 6'd13, 4'd3, 8'h10);  // R5 boundary
    issue(8'd0, 6'd31, 4'd5, 8'h3C);  // R5 top
    issue(8'd1, 6'd0, 4'd0, 8'h04);   // R6
    issue(8'hFF, 6'd31, 4'd7, 8'hFF); // R6 all ones
    issue(8'd0, 6'd32, 4'd0, 8'h00);  // R7 slot
    issue(8'd3, 6'd2, 4'd8, 8'h00);   // R7 function
    issue(8'd0, 6'd63, 4'd15, 8'h00); // R7 both

    // R8 back-to-back strobes
    @(negedge clk);
    req_i = 1'b1; bus_i = 8'd0; slot_i = 6'd5; func_i = 4'd1; offs_i = 8'h08;
    @(negedge clk);
    bus_i = 8'd9; slot_i = 6'd20; func_i = 4'd2; offs_i = 8'h0C;
    check("R8 first of pair", {31'd0, valid_o}, 32'd1);
    check("R4 first of pair", addr_o, ref_addr(8'd0, 6'd5, 4'd1, 8'h08));
    @(negedge clk);
    req_i = 1'b0;
    check("R8 second of pair", {31'd0, valid_o}, 32'd1);
    check("R6 second of pair", addr_o, ref_addr(8'd9, 6'd20, 4'd2, 8'h0C));
    last_addr = addr_o; last_map = map_o;
    @(negedge clk);
    check("R8 pair ends", {31'd0, valid_o}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      b = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
      issue(b, 6'($urandom_range(0, 36)), 4'($urandom_range(0, 9)), 8'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule